// File: doc/BRIEF.md
# Paged Host Memory Window Interface

This block is the host-facing register and address-window logic of a multiport serial controller card. A host on an ISA-style bus sees four byte-wide I/O registers. It reaches a 64K shared RAM owned by an embedded 16-bit processor through one 8K window in host memory space. Host software sets the window base address and the host interrupt line through a 16-bit configuration word, held in two I/O registers. A third register selects which of eight 8K RAM pages appears in the window, and carries the global enable for the window. A control register holds the embedded processor in reset and raises an interrupt to it.

For each host memory cycle that lands in the window, the block forms the 16-bit board RAM address from the page number and the offset within the window. It then presents that address with a chip select and a write strobe. For host reads it also raises a drive-enable for the read data. A request from the embedded processor is routed to one of seven host IRQ lines, or to none. All outputs are registered, so each one follows its cause by one clock.

Top module: `memwin_host_if`

## Requirements
- R1: After a synchronous reset, `cpu_reset` is 1 and `cpu_irq` is 0. The window is disabled, the page is 0 and the configuration word is 0x0000. All `host_irq` lines are 0, even while `proc_irq_req` is 1.
- R2: An I/O read with `io_rd` high returns its data on `io_rdata` one clock later. Register 0 reads bits 7:6 as 01 and bits 5:4 as 00. Its bit 3 reads as the stored interrupt bit and its bit 2 as the stored reset bit. Bits 1:0 read as 0, and writes to bits 7:4 and 1:0 have no effect.
- R3: Register 0 bit 2 drives `cpu_reset` and bit 3 drives `cpu_irq`, one clock after the write. Writing 0x04 holds the processor and writing 0x00 releases it. Writing 0x08 and then 0x00 gives one interrupt pulse.
- R4: In register 1, bit 7 is the window enable and bits 2:0 are the page number. Bits 6:3 read as 0, so writing 0xFF reads back 0x87.
- R5: Register 2 is the low byte and register 3 the high byte of the configuration word. Bit 3 of the word always reads 0, so writing 0xFA to register 2 reads back 0xF2.
- R6: A host memory cycle is claimed when `host_mem_valid` is high, the window is enabled, and `host_addr[23:13]` equals configuration bits 15:5. On the next clock `ram_cs` is 1, `ram_addr` is page × 0x2000 + `host_addr[12:0]`, and `ram_we` equals `host_mem_we`. For example, with word 0x0D92 and page 7, host address 0x0D9800 reaches RAM address 0xF800.
- R7: A host memory cycle outside the window, or any cycle while the window is disabled, leaves `ram_cs`, `ram_we` and `host_drv` at 0.
- R8: `host_drv` is 1 exactly in the clock after a claimed read, and is 0 after a claimed write.
- R9: With `proc_irq_req` high and configuration field bits 2:0 = f between 1 and 7, only `host_irq[f-1]` is high, one clock later. The bits stand for IRQ3, 5, 7, 10, 11, 12 and 15, in bit order 0 to 6.
- R10: When the field is 0 or `proc_irq_req` is low, all `host_irq` lines are 0 one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | Host I/O write strobe |
| io_rd | input | 1 | Host I/O read strobe |
| io_addr | input | 2 | I/O register index |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, registered |
| host_mem_valid | input | 1 | Host memory cycle present |
| host_mem_we | input | 1 | Host memory cycle is a write |
| host_addr | input | 24 | Host memory address |
| ram_cs | output | 1 | Shared RAM chip select |
| ram_we | output | 1 | Shared RAM write strobe |
| ram_addr | output | 16 | Board-relative RAM address |
| host_drv | output | 1 | Enable for driving host read data |
| cpu_reset | output | 1 | Hold the embedded processor in reset |
| cpu_irq | output | 1 | Interrupt to the embedded processor |
| proc_irq_req | input | 1 | Interrupt request from the embedded processor to the host |
| host_irq | output | 7 | Host IRQ lines 3, 5, 7, 10, 11, 12, 15 |

## Verification
The checker watches, on every clock, the properties that hold regardless of state:
- the host IRQ lines are never more than one-hot, and are high only after a pending request;
- a chip select or read-drive follows a host memory cycle;
- the in-window offset is carried into the RAM address unchanged;
- read-drive only comes with a chip select and no write strobe;
- register 0's fixed bits read correctly.

Only the bench's scenarios can show the contents that depend on state. These are:
- the page multiplied into the upper address bits;
- the base-address comparison that rejects nearby addresses;
- the read-back masking of each register;
- the exact IRQ line for each field value;
- the reset and interrupt control sequences.

// File: rtl/memwin_pkg.sv
package memwin_pkg;
  localparam int CFG_W        = 16;
  localparam int CFG_BASE_LSB = 5;
  localparam int CFG_WIN_BIT  = 4;
  localparam int CFG_RSVD_BIT = 3;
  localparam int IRQ_SEL_W    = 3;
  localparam logic [1:0] BOARD_REV = 2'b01;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_PAGE   = 2'd1,
    REG_CFG_LO = 2'd2,
    REG_CFG_HI = 2'd3
  } io_reg_e;
endpackage

// File: rtl/memwin_regs.sv
module memwin_regs
  import memwin_pkg::*;
#(
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [1:0]        io_addr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              ctrl_hold,
  output logic              ctrl_irq,
  output logic              win_en,
  output logic [PAGE_W-1:0] page,
  output logic [CFG_W-1:0]  cfg
);
  localparam logic [7:0] CFG_LO_MASK = ~(8'd1 << CFG_RSVD_BIT);

  logic [7:0] rd_mux;
  logic [7:0] page_byte;
  io_reg_e    sel;

  assign sel = io_reg_e'(io_addr);

  always_comb begin
    page_byte = '0;
    page_byte[7] = win_en;
    page_byte[PAGE_W-1:0] = page;
  end

  always_comb begin
    case (sel)
      REG_CTRL:   rd_mux = {BOARD_REV, 2'b00, ctrl_irq, ctrl_hold, 2'b00};
      REG_PAGE:   rd_mux = page_byte;
      REG_CFG_LO: rd_mux = cfg[7:0];
      default:    rd_mux = cfg[15:8];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_hold <= 1'b1;
      ctrl_irq  <= 1'b0;
      win_en    <= 1'b0;
      page      <= '0;
      cfg       <= '0;
      io_rdata  <= '0;
    end else begin
      if (io_wr) begin
        case (sel)
          REG_CTRL: begin
            ctrl_irq  <= io_wdata[3];
            ctrl_hold <= io_wdata[2];
          end
          REG_PAGE: begin
            win_en <= io_wdata[7];
            page   <= io_wdata[PAGE_W-1:0];
          end
          REG_CFG_LO: cfg[7:0]  <= io_wdata & CFG_LO_MASK;
          default:    cfg[15:8] <= io_wdata;
        endcase
      end
      if (io_rd) io_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/memwin_decode.sv
module memwin_decode
  import memwin_pkg::*;
#(
  parameter int HADDR_W = 24,
  parameter int WIN_W   = 13,
  parameter int PAGE_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    host_mem_valid,
  input  logic                    host_mem_we,
  input  logic [HADDR_W-1:0]      host_addr,
  input  logic                    win_en,
  input  logic [PAGE_W-1:0]       page,
  input  logic [CFG_W-1:0]        cfg,
  output logic                    ram_cs,
  output logic                    ram_we,
  output logic [PAGE_W+WIN_W-1:0] ram_addr,
  output logic                    host_drv
);
  localparam int BASE_W = HADDR_W - WIN_W;

  logic [BASE_W-1:0] base_cfg;
  logic              hit;

  assign base_cfg = cfg[CFG_BASE_LSB +: BASE_W];
  assign hit = host_mem_valid && win_en && (host_addr[HADDR_W-1:WIN_W] == base_cfg);

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_cs   <= 1'b0;
      ram_we   <= 1'b0;
      host_drv <= 1'b0;
      ram_addr <= '0;
    end else begin
      ram_cs   <= hit;
      ram_we   <= hit && host_mem_we;
      host_drv <= hit && !host_mem_we;
      if (hit) ram_addr <= {page, host_addr[WIN_W-1:0]};
    end
  end
endmodule

// File: rtl/memwin_irq_route.sv
module memwin_irq_route #(
  parameter int N_LINES = 7,
  parameter int SEL_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req,
  input  logic [SEL_W-1:0]   sel,
  output logic [N_LINES-1:0] host_irq
);
  for (genvar k = 0; k < N_LINES; k++) begin : g_line
    localparam logic [SEL_W-1:0] CODE = SEL_W'(k + 1);
    always_ff @(posedge clk) begin
      if (rst) host_irq[k] <= 1'b0;
      else     host_irq[k] <= req && (sel == CODE);
    end
  end
endmodule

// File: rtl/memwin_host_if.sv
module memwin_host_if
  import memwin_pkg::*;
#(
  parameter int HADDR_W = 24,
  parameter int WIN_W   = 13,
  parameter int PAGE_W  = 3,
  parameter int N_IRQ   = 7,
  localparam int RAM_AW = PAGE_W + WIN_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               io_wr,
  input  logic               io_rd,
  input  logic [1:0]         io_addr,
  input  logic [7:0]         io_wdata,
  output logic [7:0]         io_rdata,
  input  logic               host_mem_valid,
  input  logic               host_mem_we,
  input  logic [HADDR_W-1:0] host_addr,
  output logic               ram_cs,
  output logic               ram_we,
  output logic [RAM_AW-1:0]  ram_addr,
  output logic               host_drv,
  output logic               cpu_reset,
  output logic               cpu_irq,
  input  logic               proc_irq_req,
  output logic [N_IRQ-1:0]   host_irq
);
  logic              win_en;
  logic [PAGE_W-1:0] page;
  logic [CFG_W-1:0]  cfg;

  memwin_regs #(.PAGE_W(PAGE_W)) u_regs (
    .clk(clk), .rst(rst),
    .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rdata(io_rdata),
    .ctrl_hold(cpu_reset), .ctrl_irq(cpu_irq),
    .win_en(win_en), .page(page), .cfg(cfg)
  );

  memwin_decode #(.HADDR_W(HADDR_W), .WIN_W(WIN_W), .PAGE_W(PAGE_W)) u_dec (
    .clk(clk), .rst(rst),
    .host_mem_valid(host_mem_valid), .host_mem_we(host_mem_we), .host_addr(host_addr),
    .win_en(win_en), .page(page), .cfg(cfg),
    .ram_cs(ram_cs), .ram_we(ram_we), .ram_addr(ram_addr), .host_drv(host_drv)
  );

  memwin_irq_route #(.N_LINES(N_IRQ), .SEL_W(IRQ_SEL_W)) u_irq (
    .clk(clk), .rst(rst),
    .req(proc_irq_req), .sel(cfg[IRQ_SEL_W-1:0]),
    .host_irq(host_irq)
  );
endmodule

// File: rtl/memwin_checker.sv
module memwin_checker #(
  parameter int HADDR_W = 24,
  parameter int WIN_W   = 13,
  parameter int RAM_AW  = 16,
  parameter int N_IRQ   = 7
) (
  input logic               clk,
  input logic               rst,
  input logic               io_rd,
  input logic [1:0]         io_addr,
  input logic [7:0]         io_rdata,
  input logic               host_mem_valid,
  input logic [HADDR_W-1:0] host_addr,
  input logic               ram_cs,
  input logic               ram_we,
  input logic [RAM_AW-1:0]  ram_addr,
  input logic               host_drv,
  input logic               proc_irq_req,
  input logic [N_IRQ-1:0]   host_irq
);
  // R9: the host IRQ lines are at most one-hot
  assert_irq_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(host_irq));

  // R10: a host IRQ line is high only after a pending request
  assert_irq_needs_req_R10: assert property (@(posedge clk) disable iff (rst)
    (host_irq != '0) && !$past(rst) |-> $past(proc_irq_req));

  // R6: a chip select follows a host memory cycle, with the offset carried unchanged
  assert_cs_follows_cycle_R6: assert property (@(posedge clk) disable iff (rst)
    ram_cs && !$past(rst) |-> $past(host_mem_valid)
      && (ram_addr[WIN_W-1:0] == $past(host_addr[WIN_W-1:0])));

  // R8: read-drive only with a chip select and no write strobe
  assert_drv_only_read_R8: assert property (@(posedge clk) disable iff (rst)
    host_drv |-> ram_cs && !ram_we);

  // R7: no write strobe without a chip select
  assert_we_needs_cs_R7: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> ram_cs);

  // R2: fixed bits of register 0 on read-back
  assert_ctrl_fixed_bits_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(io_rd) && ($past(io_addr) == 2'd0)
      |-> (io_rdata[7:4] == 4'b0100) && (io_rdata[1:0] == 2'b00));
endmodule

bind memwin_host_if memwin_checker #(
  .HADDR_W(HADDR_W), .WIN_W(WIN_W), .RAM_AW(RAM_AW), .N_IRQ(N_IRQ)
) u_memwin_chk (
  .clk(clk), .rst(rst), .io_rd(io_rd), .io_addr(io_addr), .io_rdata(io_rdata),
  .host_mem_valid(host_mem_valid), .host_addr(host_addr),
  .ram_cs(ram_cs), .ram_we(ram_we), .ram_addr(ram_addr), .host_drv(host_drv),
  .proc_irq_req(proc_irq_req), .host_irq(host_irq)
);

// File: tb/tb_memwin_host_if.sv
module tb_memwin_host_if;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [1:0]  io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        host_mem_valid = 1'b0, host_mem_we = 1'b0;
  logic [23:0] host_addr = '0;
  logic        ram_cs, ram_we, host_drv, cpu_reset, cpu_irq;
  logic [15:0] ram_addr;
  logic        proc_irq_req = 1'b0;
  logic [6:0]  host_irq;

  always #2 clk = ~clk;

  memwin_host_if dut (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata),
    .host_mem_valid(host_mem_valid), .host_mem_we(host_mem_we), .host_addr(host_addr),
    .ram_cs(ram_cs), .ram_we(ram_we), .ram_addr(ram_addr), .host_drv(host_drv),
    .cpu_reset(cpu_reset), .cpu_irq(cpu_irq),
    .proc_irq_req(proc_irq_req), .host_irq(host_irq)
  );

  localparam int S_RDATA = 0, S_CPURST = 1, S_CPUIRQ = 2, S_CS = 3,
                 S_ADDR = 4, S_WE = 5, S_DRV = 6, S_HIRQ = 7;

  typedef struct {
    int          cyc;
    int          sel;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] actual(int sel);
    case (sel)
      S_RDATA:  return {24'b0, io_rdata};
      S_CPURST: return {31'b0, cpu_reset};
      S_CPUIRQ: return {31'b0, cpu_irq};
      S_CS:     return {31'b0, ram_cs};
      S_ADDR:   return {16'b0, ram_addr};
      S_WE:     return {31'b0, ram_we};
      S_DRV:    return {31'b0, host_drv};
      default:  return {25'b0, host_irq};
    endcase
  endfunction

  // Monitor: pops items due this cycle and compares them
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      item_t it;
      logic [31:0] a;
      it = q.pop_front();
      a = actual(it.sel);
      checks++;
      if (a !== it.exp) begin
        errors++;
        $display("FAIL %s sel=%0d actual=0x%0h expected=0x%0h", it.req, it.sel, a, it.exp);
      end
    end
  end

  // Driver helpers: called at a negedge, expectation due after the next posedge
  task automatic expect_next(int sel, logic [31:0] exp, string req);
    item_t it;
    it.cyc = cyc + 1; it.sel = sel; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic io_write(logic [1:0] a, logic [7:0] d);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    step();
    io_wr = 1'b0;
  endtask

  task automatic io_read(logic [1:0] a, logic [7:0] exp, string req);
    io_rd = 1'b1; io_addr = a;
    expect_next(S_RDATA, {24'b0, exp}, req);
    step();
    io_rd = 1'b0;
  endtask

  task automatic chk(int sel, logic [31:0] exp, string req);
    expect_next(sel, exp, req);
    step();
  endtask

  task automatic mem_cycle(logic [23:0] a, logic we, logic claim, logic [15:0] exp_addr, string req);
    host_mem_valid = 1'b1; host_mem_we = we; host_addr = a;
    expect_next(S_CS, {31'b0, claim}, req);
    expect_next(S_WE, {31'b0, claim & we}, req);
    expect_next(S_DRV, {31'b0, claim & ~we}, req);
    if (claim) expect_next(S_ADDR, {16'b0, exp_addr}, req);
    step();
    host_mem_valid = 1'b0; host_mem_we = 1'b0;
  endtask

  function automatic logic [6:0] irq_exp(int f, logic req);
    if (!req || f == 0) return 7'b0;
    return 7'(1 << (f - 1));
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    step(); step();
    // R1: reset state, with a processor request pending
    proc_irq_req = 1'b1;
    step();
    rst = 1'b0;
    chk(S_CPURST, 1, "R1");
    chk(S_CPUIRQ, 0, "R1");
    chk(S_HIRQ, 0, "R1");
    io_read(2'd0, 8'h44, "R1/R2");
    io_read(2'd1, 8'h00, "R1");
    io_read(2'd2, 8'h00, "R1");
    io_read(2'd3, 8'h00, "R1");
    proc_irq_req = 1'b0;
    mem_cycle(24'h000000, 1'b0, 1'b0, 16'h0, "R1 window off");

    // R3: release, interrupt pulse, hold again
    io_write(2'd0, 8'h00);
    chk(S_CPURST, 0, "R3 release");
    io_read(2'd0, 8'h40, "R2");
    io_write(2'd0, 8'h08);
    chk(S_CPUIRQ, 1, "R3 irq set");
    io_read(2'd0, 8'h48, "R2");
    io_write(2'd0, 8'h00);
    chk(S_CPUIRQ, 0, "R3 irq clear");
    // R2: read-only bits ignore writes
    io_write(2'd0, 8'hF3);
    io_read(2'd0, 8'h40, "R2 read-only");
    io_write(2'd0, 8'h04);
    chk(S_CPURST, 1, "R3 hold");
    chk(S_CPUIRQ, 0, "R3 hold");

    // R4: page register masking
    io_write(2'd1, 8'hFF);
    io_read(2'd1, 8'h87, "R4");
    io_write(2'd1, 8'h7A);
    io_read(2'd1, 8'h02, "R4");

    // R5: configuration word bytes and reserved bit
    io_write(2'd2, 8'hFA);
    io_read(2'd2, 8'hF2, "R5 bit3");
    io_write(2'd2, 8'h92);
    io_write(2'd3, 8'h0D);
    io_read(2'd2, 8'h92, "R5 low");
    io_read(2'd3, 8'h0D, "R5 high");

    // R6/R8: claimed cycles with base 0x0D8000
    io_write(2'd1, 8'h87);
    mem_cycle(24'h0D9800, 1'b0, 1'b1, 16'hF800, "R6/R8 read page7");
    mem_cycle(24'h0D8005, 1'b1, 1'b1, 16'hE005, "R6/R8 write page7");
    io_write(2'd1, 8'h80);
    mem_cycle(24'h0D9FFF, 1'b0, 1'b1, 16'h1FFF, "R6 page0 top");
    io_write(2'd1, 8'h83);
    mem_cycle(24'h0D8000, 1'b1, 1'b1, 16'h6000, "R6 page3");
    // R7: outside the window, then window disabled
    mem_cycle(24'h0DA000, 1'b0, 1'b0, 16'h0, "R7 above");
    mem_cycle(24'h0D7FFF, 1'b1, 1'b0, 16'h0, "R7 below");
    mem_cycle(24'h8D8000, 1'b0, 1'b0, 16'h0, "R7 high bit");
    io_write(2'd1, 8'h03);
    mem_cycle(24'h0D8010, 1'b0, 1'b0, 16'h0, "R7 disabled");

    // R9/R10: IRQ routing for every field value
    for (int f = 0; f < 8; f++) begin
      io_write(2'd2, 8'h90 | 8'(f));
      proc_irq_req = 1'b1;
      chk(S_HIRQ, {25'b0, irq_exp(f, 1'b1)}, f == 0 ? "R10 field0" : "R9");
      proc_irq_req = 1'b0;
      chk(S_HIRQ, 0, "R10 no request");
    end

    step(); step();
    done = 1'b1;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard left %0d items actual=%0d expected=0", q.size(), q.size());
    end
    summary();
  end
endmodule